// File: doc/BRIEF.md
# PCIe Link Training Supervisor

This block drives the enable line of a link training state machine and watches its status until the link can carry traffic. A start command raises the enable. The supervisor then waits for the physical layer to report link-up, then waits for the data link layer to report link-up. It then emits a single-cycle request for a directed speed change, and finally waits until the 6-bit training state code lies in the active band, 0x11 to 0x16 inclusive. This band covers normal operation, the standby sub-state and the low-power idle and wake states.

Each of the three waits polls its condition once per sample interval and gives up after a fixed number of samples. A failed wait freezes the sequence with the enable still high, and a 2-bit code names the wait that expired. A stop command drops the enable and returns the block to idle from any point. The training state machine itself lives outside this block. Both the interval length and the sample count are parameters, so the block can be scaled to any clock rate.

Top module: `link_train_supervisor`

## Requirements
- R1: After reset the enable, the speed-change request, the link-ok flag and the failure code are all 0.
- R2: A start command seen at a clock edge while idle or failed raises the enable at that edge and clears the failure code to 0.
- R3: Each wait samples its condition only at the edge that ends each interval of SAMPLE_CYCLES cycles after the wait began. The data-link flag is not examined until a sample has found the physical-layer flag high.
- R4: Once a sample finds the data-link flag high, the speed-change request is high for exactly one cycle, during the cycle after that sample. It is never issued unless both flags have been seen in order.
- R5: The final wait succeeds when a sample finds the state code in the range 0x11 to 0x16 inclusive. The block then enters the up phase.
- R6: In the up phase, link-ok equals the range test of the current state code in the same cycle, so it drops as soon as the code leaves 0x11..0x16. Outside the up phase it is 0.
- R7: If MAX_SAMPLES samples of a wait all fail, the block stops at the edge of the last sample with the enable still high. The failure code then reads 1 for the physical-layer wait, 2 for the data-link wait and 3 for the state-range wait.
- R8: A stop command clears the enable and link-ok at the next edge and returns the block to idle. It wins over a start command in the same cycle, and it leaves the failure code unchanged.
- R9: A start command during a wait or in the up phase has no effect.
- R10: A start command after a failure restarts the whole sequence from the physical-layer wait.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startCmd | input | 1 | Begin link bring-up |
| stopCmd | input | 1 | Abort and drop the training enable |
| phyUp | input | 1 | Physical-layer link-up flag |
| dllUp | input | 1 | Data-link-layer link-up flag |
| ltssmState | input | STATE_W | Current training state code |
| ltssmEn | output | 1 | Training enable |
| speedChg | output | 1 | One-cycle directed speed-change request |
| linkOk | output | 1 | Link is up and the state code is in the active band |
| timeoutCode | output | 2 | 0 none, 1 physical wait, 2 data-link wait, 3 state wait expired |

## Verification
The enable, the failure code and the phase all change at the edge that samples a command or ends a sample interval. The first wait therefore resolves SAMPLE_CYCLES edges after start, the speed-change pulse appears two intervals after start, and link-ok appears after three intervals plus one cycle. A timeout lands SAMPLE_CYCLES times MAX_SAMPLES edges after its wait began. Link-ok follows the state code in the same cycle while the link is up. The bench changes inputs on the falling edge, counts falling edges from the command, and compares each output against its expected value at the exact count where it is due. Checks on neighbouring counts confirm that nothing changes early.

// File: rtl/lbu_pkg.sv
package lbu_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_PHY,
    PH_DLL,
    PH_SPEED,
    PH_STATE,
    PH_UP,
    PH_FAIL
  } phase_e;

  localparam logic [1:0] FAIL_NONE  = 2'd0;
  localparam logic [1:0] FAIL_PHY   = 2'd1;
  localparam logic [1:0] FAIL_DLL   = 2'd2;
  localparam logic [1:0] FAIL_STATE = 2'd3;

  // Active band of the training state code (inclusive)
  localparam int ACTIVE_LO = 'h11;
  localparam int ACTIVE_HI = 'h16;

  typedef struct packed {
    logic       clrTimer;
    logic       setEn;
    logic       clrEn;
    logic       clrCode;
    logic       setCode;
    logic [1:0] failCode;
  } strobe_t;

endpackage

// File: rtl/lbu_datapath.sv
module lbu_datapath
  import lbu_pkg::*;
#(
  parameter int SAMPLE_CYCLES = 1000,
  parameter int MAX_SAMPLES   = 1000,
  parameter int STATE_W       = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            stb,
  input  logic [STATE_W-1:0] ltssmState,
  output logic               tick,
  output logic               lastSample,
  output logic               stateActive,
  output logic               ltssmEn,
  output logic [1:0]         timeoutCode
);

  localparam int IW = (SAMPLE_CYCLES > 1) ? $clog2(SAMPLE_CYCLES) : 1;
  localparam int NW = $clog2(MAX_SAMPLES + 1);
  localparam logic [IW-1:0] INTERVAL_END = IW'(SAMPLE_CYCLES - 1);
  localparam logic [NW-1:0] SAMPLE_END   = NW'(MAX_SAMPLES - 1);
  localparam logic [STATE_W-1:0] BAND_LO = STATE_W'(ACTIVE_LO);
  localparam logic [STATE_W-1:0] BAND_HI = STATE_W'(ACTIVE_HI);

  logic [IW-1:0] intervalCnt;
  logic [NW-1:0] sampleCnt;

  assign tick        = (intervalCnt == INTERVAL_END);
  assign lastSample  = tick && (sampleCnt == SAMPLE_END);
  assign stateActive = (ltssmState >= BAND_LO) && (ltssmState <= BAND_HI);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      intervalCnt <= '0;
      sampleCnt   <= '0;
    end else if (stb.clrTimer) begin
      intervalCnt <= '0;
      sampleCnt   <= '0;
    end else if (tick) begin
      intervalCnt <= '0;
      sampleCnt   <= sampleCnt + 1'b1;
    end else begin
      intervalCnt <= intervalCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ltssmEn <= 1'b0;
    end else if (stb.clrEn) begin
      ltssmEn <= 1'b0;
    end else if (stb.setEn) begin
      ltssmEn <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      timeoutCode <= FAIL_NONE;
    end else if (stb.clrCode) begin
      timeoutCode <= FAIL_NONE;
    end else if (stb.setCode) begin
      timeoutCode <= stb.failCode;
    end
  end

endmodule

// File: rtl/lbu_control.sv
module lbu_control
  import lbu_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    startCmd,
  input  logic    stopCmd,
  input  logic    phyUp,
  input  logic    dllUp,
  input  logic    tick,
  input  logic    lastSample,
  input  logic    stateActive,
  output strobe_t stb,
  output logic    speedChg,
  output logic    linkOk
);

  phase_e curPhase, nextPhase;
  logic   waiting;

  assign waiting = (curPhase == PH_PHY) || (curPhase == PH_DLL) || (curPhase == PH_STATE);

  always_comb begin
    nextPhase = curPhase;
    stb       = '0;
    if (stopCmd) begin
      nextPhase = PH_IDLE;
      stb.clrEn = 1'b1;
    end else begin
      unique case (curPhase)
        PH_IDLE, PH_FAIL: begin
          if (startCmd) begin
            nextPhase   = PH_PHY;
            stb.setEn   = 1'b1;
            stb.clrCode = 1'b1;
          end
        end
        PH_PHY: begin
          if (tick) begin
            if (phyUp) begin
              nextPhase = PH_DLL;
            end else if (lastSample) begin
              nextPhase    = PH_FAIL;
              stb.setCode  = 1'b1;
              stb.failCode = FAIL_PHY;
            end
          end
        end
        PH_DLL: begin
          if (tick) begin
            if (dllUp) begin
              nextPhase = PH_SPEED;
            end else if (lastSample) begin
              nextPhase    = PH_FAIL;
              stb.setCode  = 1'b1;
              stb.failCode = FAIL_DLL;
            end
          end
        end
        PH_SPEED: nextPhase = PH_STATE;
        PH_STATE: begin
          if (tick) begin
            if (stateActive) begin
              nextPhase = PH_UP;
            end else if (lastSample) begin
              nextPhase    = PH_FAIL;
              stb.setCode  = 1'b1;
              stb.failCode = FAIL_STATE;
            end
          end
        end
        PH_UP:   nextPhase = PH_UP;
        default: nextPhase = PH_IDLE;
      endcase
    end
    stb.clrTimer = (nextPhase != curPhase) || !waiting;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) curPhase <= PH_IDLE;
    else       curPhase <= nextPhase;
  end

  assign speedChg = (curPhase == PH_SPEED);
  assign linkOk   = (curPhase == PH_UP) && stateActive;

endmodule

// File: rtl/link_train_supervisor.sv
module link_train_supervisor
  import lbu_pkg::*;
#(
  parameter int SAMPLE_CYCLES = 1000,
  parameter int MAX_SAMPLES   = 1000,
  parameter int STATE_W       = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               startCmd,
  input  logic               stopCmd,
  input  logic               phyUp,
  input  logic               dllUp,
  input  logic [STATE_W-1:0] ltssmState,
  output logic               ltssmEn,
  output logic               speedChg,
  output logic               linkOk,
  output logic [1:0]         timeoutCode
);

  strobe_t stb;
  logic    tick, lastSample, stateActive;

  lbu_control i_control (
    .clk        (clk),
    .rstN       (rstN),
    .startCmd   (startCmd),
    .stopCmd    (stopCmd),
    .phyUp      (phyUp),
    .dllUp      (dllUp),
    .tick       (tick),
    .lastSample (lastSample),
    .stateActive(stateActive),
    .stb        (stb),
    .speedChg   (speedChg),
    .linkOk     (linkOk)
  );

  lbu_datapath #(
    .SAMPLE_CYCLES(SAMPLE_CYCLES),
    .MAX_SAMPLES  (MAX_SAMPLES),
    .STATE_W      (STATE_W)
  ) i_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .ltssmState (ltssmState),
    .tick       (tick),
    .lastSample (lastSample),
    .stateActive(stateActive),
    .ltssmEn    (ltssmEn),
    .timeoutCode(timeoutCode)
  );

endmodule

// File: rtl/lbu_checker.sv
module lbu_checker #(
  parameter int STATE_W = 6
) (
  input logic               clk,
  input logic               rstN,
  input logic               startCmd,
  input logic               stopCmd,
  input logic [STATE_W-1:0] ltssmState,
  input logic               ltssmEn,
  input logic               speedChg,
  input logic               linkOk,
  input logic [1:0]         timeoutCode
);

  logic inBand;
  assign inBand = (ltssmState >= STATE_W'('h11)) && (ltssmState <= STATE_W'('h16));

  // R4
  speed_pulse_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    speedChg |=> !speedChg);

  // R4
  speed_needs_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    speedChg |-> ltssmEn);

  // R6
  link_ok_band_chk: assert property (@(posedge clk) disable iff (!rstN)
    linkOk |-> (ltssmEn && inBand && timeoutCode == 2'd0));

  // R8
  stop_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    stopCmd |=> (!ltssmEn && !linkOk));

  // R7
  fail_keeps_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (timeoutCode != 2'd0 && $past(timeoutCode) == 2'd0) |-> ltssmEn);

  // R2
  start_clears_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ltssmEn) |-> (timeoutCode == 2'd0));

endmodule

bind link_train_supervisor lbu_checker #(.STATE_W(STATE_W)) i_lbu_checker (
  .clk        (clk),
  .rstN       (rstN),
  .startCmd   (startCmd),
  .stopCmd    (stopCmd),
  .ltssmState (ltssmState),
  .ltssmEn    (ltssmEn),
  .speedChg   (speedChg),
  .linkOk     (linkOk),
  .timeoutCode(timeoutCode)
);

// File: tb/test_link_train_supervisor.sv
module test_link_train_supervisor;

  localparam int S  = 4;
  localparam int M  = 5;
  localparam int SW = 6;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          startCmd = 1'b0;
  logic          stopCmd = 1'b0;
  logic          phyUp = 1'b0;
  logic          dllUp = 1'b0;
  logic [SW-1:0] ltssmState = '0;
  logic          ltssmEn, speedChg, linkOk;
  logic [1:0]    timeoutCode;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  link_train_supervisor #(.SAMPLE_CYCLES(S), .MAX_SAMPLES(M), .STATE_W(SW)) i_link_train_supervisor (
    .clk(clk), .rstN(rstN), .startCmd(startCmd), .stopCmd(stopCmd),
    .phyUp(phyUp), .dllUp(dllUp), .ltssmState(ltssmState),
    .ltssmEn(ltssmEn), .speedChg(speedChg), .linkOk(linkOk), .timeoutCode(timeoutCode)
  );

  function automatic int expBand(input logic [SW-1:0] code);
    return (code >= 6'h11 && code <= 6'h16) ? 1 : 0;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Drive a one-cycle start at the current falling edge; returns at N1
  task automatic pulseStart();
    startCmd = 1'b1;
    @(negedge clk);
    startCmd = 1'b0;
  endtask

  task automatic pulseStop();
    stopCmd = 1'b1;
    @(negedge clk);
    stopCmd = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    int seenPulse;
    seed = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 en", ltssmEn, 0);
    chk("R1 speed", speedChg, 0);
    chk("R1 linkOk", linkOk, 0);
    chk("R1 code", timeoutCode, 0);

    // Successful bring-up: R2 R3 R4 R5 R6
    phyUp = 1; dllUp = 1; ltssmState = 6'h11;
    pulseStart();
    chk("R2 en after start", ltssmEn, 1);
    chk("R2 code cleared", timeoutCode, 0);
    for (int k = 2; k <= 16; k++) begin
      @(negedge clk);
      chk("R4 speed pulse timing", speedChg, (k == 9) ? 1 : 0);
      chk("R5 link up timing", linkOk, (k >= 14) ? 1 : 0);
    end

    // R6 band boundaries in up phase
    ltssmState = 6'h10; @(negedge clk); chk("R6 0x10", linkOk, 0);
    ltssmState = 6'h16; @(negedge clk); chk("R6 0x16", linkOk, 1);
    ltssmState = 6'h17; @(negedge clk); chk("R6 0x17", linkOk, 0);
    ltssmState = 6'h11; @(negedge clk); chk("R6 0x11", linkOk, 1);
    for (int i = 0; i < 120; i++) begin
      ltssmState = SW'($urandom_range(0, 63));
      @(negedge clk);
      chk("R6 random code", linkOk, expBand(ltssmState));
    end
    ltssmState = 6'h12;

    // R9 start ignored while up
    pulseStart();
    seenPulse = 0;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      seenPulse += speedChg;
    end
    chk("R9 no re-run pulse", seenPulse, 0);
    chk("R9 still up", linkOk, 1);

    // R8 stop wins over start
    startCmd = 1; stopCmd = 1;
    @(negedge clk);
    startCmd = 0; stopCmd = 0;
    chk("R8 en cleared", ltssmEn, 0);
    chk("R8 linkOk cleared", linkOk, 0);
    repeat (3) @(negedge clk);
    chk("R8 stays idle", ltssmEn, 0);

    // R7 physical-layer timeout, R3 ordering
    phyUp = 0; dllUp = 1; ltssmState = 6'h11;
    pulseStart();
    seenPulse = 0;
    for (int k = 2; k <= 21; k++) begin
      @(negedge clk);
      seenPulse += speedChg;
      if (k == 20) chk("R7 no early phy timeout", timeoutCode, 0);
      if (k == 21) chk("R7 phy timeout code", timeoutCode, 1);
    end
    chk("R3 no pulse without phy", seenPulse, 0);
    chk("R7 enable held", ltssmEn, 1);
    repeat (6) @(negedge clk);
    chk("R7 frozen", timeoutCode, 1);

    // R10 restart after failure; late phy; data-link timeout
    dllUp = 0;
    pulseStart();
    chk("R10 code cleared on restart", timeoutCode, 0);
    chk("R10 enable on restart", ltssmEn, 1);
    for (int k = 2; k <= 29; k++) begin
      @(negedge clk);
      if (k == 6) phyUp = 1;
      if (k == 28) chk("R3 second sample no early fail", timeoutCode, 0);
      if (k == 29) chk("R7 dll timeout code", timeoutCode, 2);
    end
    chk("R7 enable held dll", ltssmEn, 1);

    // R7 state-range timeout
    dllUp = 1; ltssmState = 6'h17;
    pulseStart();
    for (int k = 2; k <= 30; k++) begin
      @(negedge clk);
      if (k == 9) chk("R4 pulse before state wait", speedChg, 1);
      if (k == 29) chk("R5 out-of-band not accepted", timeoutCode, 0);
      if (k == 30) chk("R7 state timeout code", timeoutCode, 3);
    end
    chk("R6 no linkOk on failure", linkOk, 0);

    // R8 stop during a wait; code kept
    pulseStop();
    chk("R8 code kept on stop", timeoutCode, 3);
    pulseStart();
    repeat (2) @(negedge clk);
    pulseStop();
    chk("R8 stop mid-wait", ltssmEn, 0);
    seenPulse = 0;
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      seenPulse += speedChg + linkOk + ltssmEn;
    end
    chk("R8 idle after stop", seenPulse, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule